// File: doc/BRIEF.md
# T1 Transmit Channel Substitution Stage

This block sits on the transmit path of a 24-channel T1 framer. Backplane data arrives one bit per clock. A frame sync pulse marks the framing bit of each 193-bit frame. The block counts bit positions, so it knows which DS0 timeslot each bit belongs to. A 24-bit select mask marks the timeslots to overwrite.

A global mode bit picks the replacement source for the selected timeslots:
- **Idle mode:** one shared, programmable 8-bit idle code, sent most significant bit first.
- **Loopback mode:** the bit at the same position from the receive-side framer output. That stream is assumed to be timeslot-aligned with the transmit stream.

Unselected timeslots and the framing bit pass through unchanged. The block also outputs a per-channel transparency flag, aligned with its serial output. A later stage uses this flag to decide whether robbed-bit signaling and bit-7 stuffing apply to the substituted data.

Configuration is written over a small synchronous register port into shadow registers. The shadow values move into the working copy only at a framing bit, so a channel is never partly substituted.

Top module: `t1_chan_subst`

## Requirements
- R1: After reset, every register reads 0, and the serial output equals the backplane input delayed by one clock.
- R2: The register map is as follows, and writes at addresses 0x08 and above are ignored and read 0.
  - 0x00, 0x01, 0x02: select mask for channels 1–8, 9–16 and 17–24.
  - 0x03: idle code.
  - 0x04: mode, bit 0 only; other bits read 0.
  - 0x05, 0x06, 0x07: transparency mask for channels 1–8, 9–16 and 17–24.
  - Reads are combinational from the address and return the last written value.
- R3: A cycle with the frame sync input high is the framing bit. The next 192 cycles carry channels 1 to 24, with 8 bits per channel. Channel n is controlled by bit (n-1) mod 8 of the mask byte at address (n-1)/8.
- R4: In idle mode (mode bit 0), a selected channel carries the idle code, with bit 7 in the first bit of the timeslot.
- R5: In loopback mode (mode bit 1), a selected channel carries the receive input bit taken in the same cycle.
- R6: A channel whose select bit is 0 carries the backplane input bit.
- R7: The framing bit is always passed from the backplane input, whatever the mask.
- R8: Every output bit appears one clock after the input bit it is derived from.
- R9: The transparency output is 1 during the output bits of a channel whose transparency bit is set. It is 0 on the framing bit and during all other channels.
- R10: A register write takes effect at the next framing bit. Writes made during a frame leave the rest of that frame unchanged.
- R11: Without frame sync pulses, a framing bit recurs every 193 cycles after the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | High in the framing-bit cycle |
| tx_ser_in | input | 1 | Backplane serial data |
| rx_ser_in | input | 1 | Receive framer serial data, timeslot-aligned |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| tx_ser_out | output | 1 | Substituted serial data |
| chan_transparent | output | 1 | Transparency flag for the current output bit |

## Verification
The main function is tested with several kinds of masks, each of which separates specific mapping faults:
- **Empty mask:** shows plain pass-through.
- **Mask with only channel 1 and channel 24:** exposes reversed or shifted channel-to-bit mapping at both ends of the frame.
- **Full masks in both modes:** tell idle-code insertion apart from loopback.
- **Random masks, idle codes and modes:** use independent random backplane and receive bits, so a wrong source choice shows up within a few bits.

Some idle codes are chosen to catch specific faults:
- **Idle codes 0x80 and 0x01:** expose bit-order reversal.
- **Idle codes 0xFF and 0x00:** separate a stuck output from a correct one.

Writes issued in the middle of a frame check that a new setting waits for the next framing bit. A frame without a sync pulse checks the free-running 193-bit wrap.

// File: rtl/t1_chan_subst.sv
`timescale 1ns/1ps
module t1_chan_subst #(
  parameter int NCH = 24,
  parameter int DW  = 8,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic          tx_ser_in,
  input  logic          rx_ser_in,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          tx_ser_out,
  output logic          chan_transparent
);
  localparam int NREG   = (NCH + DW - 1) / DW;
  localparam int MW     = NREG * DW;
  localparam int CHW    = $clog2(NCH);
  localparam int BW     = $clog2(DW);
  localparam int A_IDLE = NREG;
  localparam int A_MODE = NREG + 1;
  localparam int A_TR   = NREG + 2;

  logic [MW-1:0]  mask_sh, tr_sh;
  logic [DW-1:0]  idle_sh, idle_act;
  logic           mode_sh, mode_act;
  logic [NCH-1:0] mask_act, tr_act;
  logic           fr_q;
  logic [CHW-1:0] ch_q;
  logic [BW-1:0]  bt_q;
  logic           ser_q, tr_q;

  wire at_fbit  = fsync | fr_q;
  wire last_bit = (ch_q == CHW'(NCH-1)) && (bt_q == BW'(DW-1));
  wire sel      = !at_fbit && mask_act[ch_q];
  wire sub_bit  = mode_act ? rx_ser_in : idle_act[BW'(DW-1) - bt_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fr_q <= 1'b1;
      ch_q <= '0;
      bt_q <= '0;
    end else if (at_fbit) begin
      fr_q <= 1'b0;
      ch_q <= '0;
      bt_q <= '0;
    end else if (last_bit) begin
      fr_q <= 1'b1;
    end else if (bt_q == BW'(DW-1)) begin
      bt_q <= '0;
      ch_q <= ch_q + CHW'(1);
    end else begin
      bt_q <= bt_q + BW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_sh <= '0;
      tr_sh   <= '0;
      idle_sh <= '0;
      mode_sh <= 1'b0;
    end else if (reg_we) begin
      for (int r = 0; r < NREG; r++) begin
        if (reg_addr == AW'(r))        mask_sh[r*DW +: DW] <= reg_wdata;
        if (reg_addr == AW'(A_TR + r)) tr_sh[r*DW +: DW]   <= reg_wdata;
      end
      if (reg_addr == AW'(A_IDLE)) idle_sh <= reg_wdata;
      if (reg_addr == AW'(A_MODE)) mode_sh <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int r = 0; r < NREG; r++) begin
      if (reg_addr == AW'(r))        reg_rdata = mask_sh[r*DW +: DW];
      if (reg_addr == AW'(A_TR + r)) reg_rdata = tr_sh[r*DW +: DW];
    end
    if (reg_addr == AW'(A_IDLE)) reg_rdata = idle_sh;
    if (reg_addr == AW'(A_MODE)) reg_rdata = {{(DW-1){1'b0}}, mode_sh};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_act <= '0;
      tr_act   <= '0;
      idle_act <= '0;
      mode_act <= 1'b0;
    end else if (at_fbit) begin
      mask_act <= mask_sh[NCH-1:0];
      tr_act   <= tr_sh[NCH-1:0];
      idle_act <= idle_sh;
      mode_act <= mode_sh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_q <= 1'b0;
      tr_q  <= 1'b0;
    end else begin
      ser_q <= sel ? sub_bit : tx_ser_in;
      tr_q  <= !at_fbit && tr_act[ch_q];
    end
  end

  assign tx_ser_out       = ser_q;
  assign chan_transparent = tr_q;

  assert_ch_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ch_q <= CHW'(NCH-1));
  assert_fbit_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    at_fbit |=> tx_ser_out == $past(tx_ser_in));
  assert_unsel_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_fbit && !mask_act[ch_q]) |=> tx_ser_out == $past(tx_ser_in));
  assert_loop_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_fbit && mask_act[ch_q] && mode_act) |=> tx_ser_out == $past(rx_ser_in));
  assert_tr_fbit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    at_fbit |=> !chan_transparent);
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !at_fbit |=> ($stable(mask_act) && $stable(idle_act) && $stable(mode_act) && $stable(tr_act)));
endmodule

// File: tb/t1_chan_subst_tb_top.sv
`timescale 1ns/1ps
module t1_chan_subst_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, tx = 1'b0, rx = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic ser_out, tr_out;
  int checks = 0, errors = 0;
  bit done = 0;

  t1_chan_subst dut_i (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .tx_ser_in(tx), .rx_ser_in(rx),
    .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .tx_ser_out(ser_out), .chan_transparent(tr_out)
  );

  always #2.5 clk = ~clk;

  logic [7:0] b_sh [8];
  logic [7:0] b_act [8];
  logic [7:0] wq_a [16];
  logic [7:0] wq_d [16];
  int wq_n = 0;
  bit have_prev = 0;
  logic e_ser, e_tr;
  string e_tag, e_lbl;
  int e_pos;

  function automatic logic [23:0] act_mask();
    return {b_act[2], b_act[1], b_act[0]};
  endfunction
  function automatic logic [23:0] act_tr();
    return {b_act[7], b_act[6], b_act[5]};
  endfunction

  task automatic chk(input string lbl, input string tag, input logic act, input logic exp, input int pos);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s pos %0d actual %0b expected %0b", lbl, tag, pos, act, exp);
    end
  endtask

  task automatic qw(input logic [7:0] a, input logic [7:0] d);
    wq_a[wq_n] = a; wq_d[wq_n] = d; wq_n++;
  endtask

  task automatic check_prev();
    if (have_prev) begin
      chk(e_lbl, {e_tag, " R8 ser"}, ser_out, e_ser, e_pos);
      chk(e_lbl, "R9 transparent", tr_out, e_tr, e_pos);
    end
  endtask

  task automatic run_frame(input bit sync, input string lbl);
    int rd = 0;
    for (int p = 0; p < 193; p++) begin
      @(negedge clk);
      check_prev();
      tx = 1'($urandom); rx = 1'($urandom);
      fsync = sync && (p == 0);
      if (p >= 2 && rd < wq_n) begin
        we = 1'b1; addr = wq_a[rd]; wdata = wq_d[rd];
        if (wq_a[rd] < 8) b_sh[wq_a[rd]] = (wq_a[rd] == 8'h04) ? (wq_d[rd] & 8'h01) : wq_d[rd];
        rd++;
      end else begin
        we = 1'b0;
      end
      e_lbl = lbl; e_pos = p;
      if (p == 0) begin
        e_ser = tx; e_tr = 1'b0; e_tag = "R7";
        for (int i = 0; i < 8; i++) b_act[i] = b_sh[i];
      end else begin
        int c = (p - 1) / 8;
        int b = (p - 1) % 8;
        logic [23:0] m = act_mask();
        logic [23:0] t = act_tr();
        e_tr = t[c];
        if (!m[c]) begin
          e_ser = tx; e_tag = "R6";
        end else if (b_act[4][0]) begin
          e_ser = rx; e_tag = "R5";
        end else begin
          e_ser = b_act[3][7-b]; e_tag = "R4 R3";
        end
      end
      have_prev = 1;
    end
    we = 1'b0;
    wq_n = 0;
  endtask

  task automatic read_all(input string lbl);
    for (int a = 0; a < 9; a++) begin
      addr = 8'(a);
      #0.2;
      checks++;
      if (rdata !== ((a < 8) ? b_sh[a] : 8'h00)) begin
        errors++;
        $display("FAIL %s addr %0d actual %h expected %h", lbl, a, rdata, (a < 8) ? b_sh[a] : 8'h00);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0193));
    for (int i = 0; i < 8; i++) begin b_sh[i] = 8'h00; b_act[i] = 8'h00; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    read_all("R1 reset regs");
    chk("R1", "reset ser", ser_out, 1'b0, 0);
    chk("R1", "reset transparent", tr_out, 1'b0, 0);

    qw(8'h03, 8'hA5); qw(8'h00, 8'h01); qw(8'h02, 8'h80);
    qw(8'h05, 8'h01); qw(8'h07, 8'h80); qw(8'h04, 8'hFE); qw(8'h08, 8'h77);
    run_frame(1, "R1 R10 passthrough");
    read_all("R2 readback");
    run_frame(1, "R3 ends idle A5");

    qw(8'h03, 8'h80); qw(8'h01, 8'hFF);
    run_frame(1, "R10 pending 80");
    run_frame(1, "R4 idle 80");
    qw(8'h03, 8'h01);
    run_frame(1, "R10 pending 01");
    run_frame(1, "R4 idle 01");

    qw(8'h00, 8'hFF); qw(8'h01, 8'hFF); qw(8'h02, 8'hFF); qw(8'h03, 8'hFF);
    run_frame(1, "R10 pending FF");
    run_frame(1, "R4 idle FF all");
    qw(8'h03, 8'h00);
    run_frame(1, "R10 pending 00");
    run_frame(1, "R4 idle 00 all");
    qw(8'h04, 8'h01);
    run_frame(1, "R10 pending loop");
    run_frame(1, "R5 loopback all");
    run_frame(0, "R11 free run");
    read_all("R2 readback loop");

    for (int f = 0; f < 6; f++) begin
      qw(8'h00, 8'($urandom)); qw(8'h01, 8'($urandom)); qw(8'h02, 8'($urandom));
      qw(8'h03, 8'($urandom)); qw(8'h04, 8'($urandom));
      qw(8'h05, 8'($urandom)); qw(8'h06, 8'($urandom)); qw(8'h07, 8'($urandom));
      run_frame(1, "R4 R5 R6 random");
    end
    run_frame(0, "R11 free run random");
    @(negedge clk);
    check_prev();
    read_all("R2 final");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule